// File: doc/BRIEF.md
# Manual-Mode Serial Frame Controller for a Multichannel Converter

This block is the digital serial front end of a sixteen-input sampling converter that runs with host-chosen channel selection. A host acts as master on a four-wire serial link (active-low chip select, serial clock, data in, data out). Each 16-bit command selects the channel to convert next and can update a small set of held settings: input range, power-down, output header format and general-purpose output levels. The block drives the analog multiplexer select, keeps those settings, and shifts out one 16-bit result word per frame.

Channel selection is pipelined. A command sent in frame N is decoded when that frame closes. The multiplexer moves to the new channel on the second falling serial clock edge of frame N+1. The channel is sampled when frame N+1 closes, and its 12-bit result leaves in frame N+2. The results come in on a parallel bus that holds one 12-bit value per channel. The serial pins are sampled with the system clock through a synchronizer. The link has no back-pressure: the master owns the pace, and the design keeps up as long as each serial clock phase lasts longer than its input latency of four system clocks.

A frame is the time chip select is held low. Data in is taken on rising serial clock edges, and data out changes on falling edges. A frame counts only when at least 16 rising edges arrive, and only the first 16 bits are used.

Top module: `adcm_manual_frontend`

## Requirements
- R1: After reset, `sdo`, `mux_sel`, `range_2x`, `pwr_down`, `mode_err` and `gpio_out` are all 0. The internal next-channel address and the converted-channel registers are also 0.
- R2: The command is received MSB first, one bit per rising `sclk` edge. The result word is sent MSB first: bit 15 is on `sdo` once chip select has fallen, and each falling `sclk` edge moves to the next lower bit.
- R3: A complete frame N whose command field is valid and carries address A (bits 10..7, bit 10 MSB) sets `mux_sel` to A on the second falling `sclk` edge of frame N+1. The result word of frame N+2 carries the result of channel A, as the parallel bus held it when frame N+1 closed.
- R4: When the held header-select bit (command bit 4) is 0, result bits 15..12 carry the number of the converted channel and bits 11..0 carry its result.
- R5: When the held header-select bit is 1, result bits 15..12 carry the four GPIO states with GPIO3 on bit 15. A pin whose `gpio_dir` bit is 1 shows its held output level; any other pin shows `gpio_in`. These states are taken when chip select falls. Bits 11..0 still carry the result.
- R6: In a valid complete frame with bit 11 = 1, the settings are loaded from that command: bit 6 to range, bit 5 to power-down, bit 4 to header select, bits 3..0 to GPIO3..GPIO0. With bit 11 = 0, those settings keep their values and the address still takes effect. Settings change only when a frame closes.
- R7: Command GPIO bits update only pins with `gpio_dir` = 1 at the close of the frame. A pin configured as input keeps its held `gpio_out` level.
- R8: In a valid frame with bits 11 and 5 both set, `pwr_down` rises on the 16th falling `sclk` edge. It stays high until a valid complete frame with bit 11 = 1 and bit 5 = 0 closes.
- R9: A complete frame whose bits 15..12 are not 0001 sets `mode_err` when it closes. It changes no setting, no address and no power-down state. The next valid complete frame clears `mode_err`. Such a frame still shifts out its result and still advances the sampling pipeline.
- R10: A frame with fewer than 16 rising `sclk` edges decodes nothing, samples nothing and leaves the settings, `mode_err` and the result pipeline unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Frame select from master, active low |
| sclk | input | 1 | Serial clock from master |
| sdi | input | 1 | Serial command data |
| sdo | output | 1 | Serial result data |
| ch_results | input | NUM_CH*12 | Latest 12-bit value of each channel, channel 0 in the lowest bits |
| gpio_dir | input | 4 | Pin direction, 1 = output |
| gpio_in | input | 4 | Sensed levels of the GPIO pins |
| gpio_out | output | 4 | Held GPIO output levels |
| mux_sel | output | 4 | Analog multiplexer channel select |
| range_2x | output | 1 | 1 selects the doubled input range |
| pwr_down | output | 1 | Power-down status |
| mode_err | output | 1 | Last complete frame had an unsupported mode field |

## Verification
Two things happen at the same closing chip-select edge: the decode of the new command and the sampling of the channel that the previous command selected. The bench sends back-to-back commands with different addresses and changes the result bus after every frame. It then checks that the word of frame N+2 carries frame N's channel, with the value the bus held at the close of frame N+1, and not the address just decoded. A second overlap is the power-down set on the 16th falling edge of a frame followed by a decode at its close. The bench checks `pwr_down` between those two edges. It then checks that only a valid frame with bit 11 set clears it, while an invalid-mode frame leaves it set.

// File: rtl/adcm_pkg.sv
package adcm_pkg;
  localparam int CMD_W = 16;
  localparam int HDR_W = 4;
  localparam int RES_W = CMD_W - HDR_W;
  localparam int GPIO_W = 4;
  localparam int ADDR_W = 4;
  localparam logic [3:0] MODE_MANUAL = 4'b0001;

  // Command word layout, MSB first on the wire.
  typedef struct packed {
    logic [3:0]        mode;
    logic              prog;
    logic [ADDR_W-1:0] addr;
    logic              rng;
    logic              pd;
    logic              hdr_gpio;
    logic [GPIO_W-1:0] gpio;
  } cmd_t;
endpackage

// File: rtl/adcm_in_sync.sv
module adcm_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic frame_on,
  output logic cs_fall_p,
  output logic cs_rise_p,
  output logic sck_rise_p,
  output logic sck_fall_p,
  output logic sdi_s
);
  localparam logic [2:0] IDLE_VAL = 3'b100; // {cs, sclk, sdi}

  logic [2:0] stg [STAGES];
  logic       p_cs, p_sck;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= IDLE_VAL;
          else        stg[g] <= {cs_n, sclk, sdi};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= IDLE_VAL;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_cs  <= 1'b1;
      p_sck <= 1'b0;
    end else begin
      p_cs  <= stg[STAGES-1][2];
      p_sck <= stg[STAGES-1][1];
    end
  end

  assign frame_on   = !stg[STAGES-1][2];
  assign cs_fall_p  = !stg[STAGES-1][2] && p_cs;
  assign cs_rise_p  = stg[STAGES-1][2] && !p_cs;
  assign sck_rise_p = stg[STAGES-1][1] && !p_sck;
  assign sck_fall_p = !stg[STAGES-1][1] && p_sck;
  assign sdi_s      = stg[STAGES-1][0];
endmodule

// File: rtl/adcm_rx_frame.sv
module adcm_rx_frame
  import adcm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_on,
  input  logic             cs_fall_p,
  input  logic             cs_rise_p,
  input  logic             sck_rise_p,
  input  logic             sck_fall_p,
  input  logic             sdi_s,
  output logic [CMD_W-1:0] word,
  output logic             done_p,
  output logic             sw_p,
  output logic             pd_p
);
  localparam int CNT_W = $clog2(CMD_W) + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [CMD_W-1:0] shreg;
  logic [CNT_W-1:0] rcnt, fcnt;
  logic             full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      rcnt  <= '0;
      fcnt  <= '0;
    end else if (cs_fall_p) begin
      rcnt <= '0;
      fcnt <= '0;
    end else if (frame_on) begin
      if (sck_rise_p && !full) begin
        shreg <= {shreg[CMD_W-2:0], sdi_s};
        rcnt  <= rcnt + 1'b1;
      end
      if (sck_fall_p && fcnt != CNT_MAX) fcnt <= fcnt + 1'b1;
    end
  end

  assign full   = (rcnt == FULL_CNT);
  assign word   = shreg;
  assign done_p = cs_rise_p && full;
  assign sw_p   = frame_on && sck_fall_p && (fcnt == CNT_W'(1));
  assign pd_p   = frame_on && sck_fall_p && (fcnt == FULL_CNT - 1'b1) && full;
endmodule

// File: rtl/adcm_cfg_regs.sv
module adcm_cfg_regs
  import adcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CMD_W-1:0]  word,
  input  logic              done_p,
  input  logic              pd_p,
  input  logic [GPIO_W-1:0] gpio_dir,
  output logic [ADDR_W-1:0] next_ch,
  output logic              rng,
  output logic              pd,
  output logic              hdr_gpio,
  output logic [GPIO_W-1:0] gpo,
  output logic              mode_err
);
  cmd_t cmd;
  logic valid;

  assign cmd   = cmd_t'(word);
  assign valid = (cmd.mode == MODE_MANUAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_ch  <= '0;
      rng      <= 1'b0;
      pd       <= 1'b0;
      hdr_gpio <= 1'b0;
      gpo      <= '0;
      mode_err <= 1'b0;
    end else if (done_p) begin
      mode_err <= !valid;
      if (valid) begin
        next_ch <= cmd.addr;
        if (cmd.prog) begin
          rng      <= cmd.rng;
          pd       <= cmd.pd;
          hdr_gpio <= cmd.hdr_gpio;
          gpo      <= (gpo & ~gpio_dir) | (cmd.gpio & gpio_dir);
        end
      end
    end else if (pd_p && valid && cmd.prog && cmd.pd) begin
      pd <= 1'b1;
    end
  end
endmodule

// File: rtl/adcm_chan_pipe.sv
module adcm_chan_pipe
  import adcm_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sw_p,
  input  logic                    done_p,
  input  logic [ADDR_W-1:0]       next_ch,
  input  logic [NUM_CH*RES_W-1:0] ch_results,
  output logic [ADDR_W-1:0]       mux_sel,
  output logic [ADDR_W-1:0]       conv_ch,
  output logic [RES_W-1:0]        conv_data
);
  logic [RES_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(mux_sel) == c) picked = ch_results[c*RES_W +: RES_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_sel   <= '0;
      conv_ch   <= '0;
      conv_data <= '0;
    end else begin
      if (sw_p) mux_sel <= next_ch;
      if (done_p) begin
        conv_ch   <= mux_sel;
        conv_data <= picked;
      end
    end
  end
endmodule

// File: rtl/adcm_tx_frame.sv
module adcm_tx_frame
  import adcm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_on,
  input  logic             cs_fall_p,
  input  logic             cs_rise_p,
  input  logic             sck_fall_p,
  input  logic [CMD_W-1:0] load_word,
  output logic             sdo
);
  logic [CMD_W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      sdo  <= 1'b0;
    end else if (cs_fall_p) begin
      sreg <= load_word;
      sdo  <= load_word[CMD_W-1];
    end else if (cs_rise_p) begin
      sdo <= 1'b0;
    end else if (frame_on && sck_fall_p) begin
      sreg <= {sreg[CMD_W-2:0], 1'b0};
      sdo  <= sreg[CMD_W-2];
    end
  end
endmodule

// File: rtl/adcm_manual_frontend.sv
module adcm_manual_frontend
  import adcm_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    sclk,
  input  logic                    sdi,
  output logic                    sdo,
  input  logic [NUM_CH*RES_W-1:0] ch_results,
  input  logic [GPIO_W-1:0]       gpio_dir,
  input  logic [GPIO_W-1:0]       gpio_in,
  output logic [GPIO_W-1:0]       gpio_out,
  output logic [ADDR_W-1:0]       mux_sel,
  output logic                    range_2x,
  output logic                    pwr_down,
  output logic                    mode_err
);
  logic              frame_on, cs_fall_p, cs_rise_p, sck_rise_p, sck_fall_p, sdi_s;
  logic [CMD_W-1:0]  word;
  logic              done_p, sw_p, pd_p;
  logic [ADDR_W-1:0] next_ch, conv_ch;
  logic [RES_W-1:0]  conv_data;
  logic              hdr_gpio;
  logic [GPIO_W-1:0] pin_view;
  logic [HDR_W-1:0]  header;
  logic [CMD_W-1:0]  load_word;

  adcm_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .frame_on(frame_on), .cs_fall_p(cs_fall_p), .cs_rise_p(cs_rise_p),
    .sck_rise_p(sck_rise_p), .sck_fall_p(sck_fall_p), .sdi_s(sdi_s)
  );

  adcm_rx_frame u_rx (
    .clk(clk), .rst_n(rst_n), .frame_on(frame_on), .cs_fall_p(cs_fall_p),
    .cs_rise_p(cs_rise_p), .sck_rise_p(sck_rise_p), .sck_fall_p(sck_fall_p),
    .sdi_s(sdi_s), .word(word), .done_p(done_p), .sw_p(sw_p), .pd_p(pd_p)
  );

  adcm_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .word(word), .done_p(done_p), .pd_p(pd_p),
    .gpio_dir(gpio_dir), .next_ch(next_ch), .rng(range_2x), .pd(pwr_down),
    .hdr_gpio(hdr_gpio), .gpo(gpio_out), .mode_err(mode_err)
  );

  adcm_chan_pipe #(.NUM_CH(NUM_CH)) u_pipe (
    .clk(clk), .rst_n(rst_n), .sw_p(sw_p), .done_p(done_p),
    .next_ch(next_ch), .ch_results(ch_results), .mux_sel(mux_sel),
    .conv_ch(conv_ch), .conv_data(conv_data)
  );

  // Output pins show their held level, input pins their sensed level.
  assign pin_view  = (gpio_dir & gpio_out) | (~gpio_dir & gpio_in);
  assign header    = hdr_gpio ? pin_view : conv_ch;
  assign load_word = {header, conv_data};

  adcm_tx_frame u_tx (
    .clk(clk), .rst_n(rst_n), .frame_on(frame_on), .cs_fall_p(cs_fall_p),
    .cs_rise_p(cs_rise_p), .sck_fall_p(sck_fall_p), .load_word(load_word),
    .sdo(sdo)
  );
endmodule

// File: rtl/adcm_manual_frontend_chk.sv
module adcm_manual_frontend_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sdo,
  input logic [3:0] mux_sel,
  input logic       range_2x,
  input logic       pwr_down,
  input logic       mode_err,
  input logic [3:0] gpio_out,
  input logic [3:0] gpio_dir,
  input logic       cs_fall_p,
  input logic       cs_rise_p,
  input logic       sck_fall_p,
  input logic       done_p
);
  // R2: serial output moves only at a frame edge or a falling serial clock
  p_sdo_edges_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(cs_fall_p || cs_rise_p || sck_fall_p));

  // R3: multiplexer select moves only on a falling serial clock edge
  p_mux_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mux_sel) |-> $past(sck_fall_p));

  // R6: the range setting changes only when a complete frame closes
  p_range_at_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(range_2x) |-> $past(done_p));

  // R7: input-configured pins keep their held output level
  p_input_pin_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((gpio_out ^ $past(gpio_out)) & ~$past(gpio_dir)) == 4'b0000);

  // R8: power-down is released only by a valid closing frame
  p_pd_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> ($past(done_p) && !mode_err));

  // R9: a rejected frame leaves the settings alone
  p_bad_mode_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_err) |-> ($stable(range_2x) && $stable(gpio_out) && $stable(pwr_down)));
endmodule

bind adcm_manual_frontend adcm_manual_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .mux_sel(mux_sel),
  .range_2x(range_2x), .pwr_down(pwr_down), .mode_err(mode_err),
  .gpio_out(gpio_out), .gpio_dir(gpio_dir), .cs_fall_p(cs_fall_p),
  .cs_rise_p(cs_rise_p), .sck_fall_p(sck_fall_p), .done_p(done_p)
);

// File: tb/sim_adcm_manual_frontend.sv
`timescale 1ns/1ps
module sim_adcm_manual_frontend;
  localparam int NCH  = 16;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [NCH*12-1:0] ch_results;
  logic [3:0] gpio_dir = 4'h0, gpio_in = 4'h0;
  logic sdo, range_2x, pwr_down, mode_err;
  logic [3:0] gpio_out, mux_sel;

  adcm_manual_frontend #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .ch_results(ch_results), .gpio_dir(gpio_dir), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .mux_sel(mux_sel), .range_2x(range_2x),
    .pwr_down(pwr_down), .mode_err(mode_err)
  );

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0, phase = 0;
  logic finished = 1'b0;

  // Reference model state
  logic [3:0]  m_next = 4'h0, m_mux = 4'h0, m_cch = 4'h0, m_gpo = 4'h0;
  logic [11:0] m_cdata = 12'h000;
  logic        m_rng = 1'b0, m_pd = 1'b0, m_hdr = 1'b0, m_err = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [11:0] res_of(int c, int ph);
    return 12'((c * 37 + ph * 211 + 5) % 4096);
  endfunction

  function automatic logic [15:0] mk(logic [3:0] mode, logic prog, logic [3:0] addr,
                                     logic rng, logic pd, logic hdr, logic [3:0] gp);
    return {mode, prog, addr, rng, pd, hdr, gp};
  endfunction

  task automatic set_results();
    for (int c = 0; c < NCH; c++) ch_results[c*12 +: 12] = res_of(c, phase);
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: collect the serial word and compare against the scoreboard
  logic [15:0] rx_word;
  int          rx_cnt = 0;
  always @(negedge cs_n) rx_cnt = 0;
  always @(posedge sclk) if (!cs_n) begin
    rx_word = {rx_word[14:0], sdo};
    rx_cnt++;
  end
  always @(posedge cs_n) if (rx_cnt == 16) begin
    if (exp_q.size() == 0) chk("R2 unexpected frame", rx_word, 16'hxxxx);
    else begin
      automatic logic [15:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(t, rx_word, e);
    end
  end

  // Driver: one frame of nbits clocks, updating the model alongside
  task automatic xfer(logic [15:0] cmd, int nbits, string tag);
    automatic logic valid = (cmd[15:12] == 4'b0001);
    if (nbits == 16) begin
      automatic logic [3:0] view = (gpio_dir & m_gpo) | (~gpio_dir & gpio_in);
      exp_q.push_back({m_hdr ? view : m_cch, m_cdata});
      tag_q.push_back({tag, " R2 result word"});
    end
    cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      sdi = cmd[15-i];
      wt(HALF);
      sclk = 1'b1;
      wt(HALF);
      sclk = 1'b0;
      if (i == 1) m_mux = m_next;
      wt(HALF);
      if (i == 1) chk("R3 mux switch on second falling edge", 16'(mux_sel), 16'(m_mux));
    end
    if (nbits == 16) begin
      m_pd = m_pd | (valid & cmd[11] & cmd[5]);
      chk("R8 power-down after 16th falling edge", 16'(pwr_down), 16'(m_pd));
    end
    cs_n = 1'b1;
    wt(HALF);
    if (nbits == 16) begin
      m_cch   = m_mux;
      m_cdata = res_of(int'(m_mux), phase);
      m_err   = !valid;
      if (valid) begin
        m_next = cmd[10:7];
        if (cmd[11]) begin
          m_rng = cmd[6];
          m_pd  = cmd[5];
          m_hdr = cmd[4];
          m_gpo = (m_gpo & ~gpio_dir) | (cmd[3:0] & gpio_dir);
        end
      end
    end
    phase++;
    set_results();
    wt(HALF);
  endtask

  task automatic chk_pins(string req);
    chk({req, " range"}, 16'(range_2x), 16'(m_rng));
    chk({req, " gpio_out"}, 16'(gpio_out), 16'(m_gpo));
    chk({req, " mode_err"}, 16'(mode_err), 16'(m_err));
    chk({req, " pwr_down"}, 16'(pwr_down), 16'(m_pd));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    set_results();
    wt(5);
    rst_n = 1'b1;
    wt(5);
    // R1 reset state
    chk("R1 sdo", 16'(sdo), 16'h0);
    chk("R1 mux_sel", 16'(mux_sel), 16'h0);
    chk_pins("R1");

    gpio_dir = 4'hF;
    // R6 load settings, address 4
    xfer(mk(4'd1, 1'b1, 4'd4, 1'b1, 1'b0, 1'b0, 4'h5), 16, "R6");
    chk_pins("R6 load");
    // R6 keep settings, address still applies; R3 pipeline
    xfer(mk(4'd1, 1'b0, 4'd7, 1'b0, 1'b1, 1'b1, 4'hA), 16, "R3");
    chk_pins("R6 keep");
    xfer(mk(4'd1, 1'b0, 4'd9, 1'b0, 1'b0, 1'b0, 4'h0), 16, "R3");
    xfer(mk(4'd1, 1'b0, 4'd2, 1'b0, 1'b0, 1'b0, 4'h0), 16, "R4 channel header");
    // R5 / R7 GPIO header and input-pin masking
    gpio_dir = 4'h3;
    gpio_in  = 4'hA;
    xfer(mk(4'd1, 1'b1, 4'd2, 1'b0, 1'b0, 1'b1, 4'hF), 16, "R4");
    chk_pins("R7 input pins kept");
    xfer(mk(4'd1, 1'b0, 4'd5, 1'b0, 1'b0, 1'b0, 4'h0), 16, "R5 gpio header");
    gpio_in = 4'h4;
    xfer(mk(4'd1, 1'b0, 4'd5, 1'b0, 1'b0, 1'b0, 4'h0), 16, "R5 gpio header");
    // R9 bad mode ignored
    xfer(mk(4'd2, 1'b1, 4'd15, 1'b1, 1'b1, 1'b0, 4'hF), 16, "R9");
    chk_pins("R9 rejected");
    xfer(mk(4'd1, 1'b0, 4'd6, 1'b0, 1'b0, 1'b0, 4'h0), 16, "R9 after reject");
    chk_pins("R9 cleared");
    // R10 aborted frame
    xfer(mk(4'd1, 1'b1, 4'd12, 1'b1, 1'b1, 1'b0, 4'hF), 8, "R10");
    chk_pins("R10 abort");
    xfer(mk(4'd1, 1'b0, 4'd11, 1'b0, 1'b0, 1'b0, 4'h0), 16, "R10 after abort");
    // R8 power-down set, hold and release
    xfer(mk(4'd1, 1'b1, 4'd3, 1'b0, 1'b1, 1'b0, 4'h0), 16, "R8");
    chk_pins("R8 set");
    xfer(mk(4'd1, 1'b0, 4'd3, 1'b0, 1'b0, 1'b0, 4'h0), 16, "R8");
    chk_pins("R8 hold");
    xfer(mk(4'd3, 1'b1, 4'd3, 1'b0, 1'b0, 1'b0, 4'h0), 16, "R9");
    chk_pins("R8 hold through rejected frame");
    xfer(mk(4'd1, 1'b1, 4'd8, 1'b1, 1'b0, 1'b0, 4'h0), 16, "R8");
    chk_pins("R8 release");
    xfer(mk(4'd1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 4'h0), 16, "R3 flush");
    xfer(mk(4'd1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 4'h0), 16, "R3 flush");
    wt(10);
    chk("R2 scoreboard drained", 16'(exp_q.size()), 16'h0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule